// File: doc/BRIEF.md
# Positional Frame Parser and Demultiplexer

This block sits behind a line decoder that turns each received 10-bit code into a byte, a control flag (K) and a code-error flag. It rebuilds fixed-length frames from that symbol stream and fans the payload out to per-channel sample registers. A frame opens with a control symbol and carries exactly one data byte per channel. Which channel a byte belongs to is given only by its position after the opening symbol, so the frame carries no addresses and no closing marker.

Bytes are first collected in shadow registers. All channel outputs are loaded together on a one-cycle strobe, and only when the whole frame arrived clean. A frame with any bad symbol, or one cut short by a new opening symbol, is thrown away. No resend is requested, because the next sample frame follows anyway. A control symbol other than the plain header value also opens a frame, and its code is reported as a one-cycle command pulse. A saturating drop counter and a sticky lock flag summarise link health.

Top module: `fp_frame_demux`

## Requirements
- R1: A frame opens only on a symbol with `sym_k_i`=1 and `sym_err_i`=0. Data symbols seen after reset before such a symbol are ignored, and so is a K symbol that carries an error: no strobe, and the channel outputs stay 0.
- R2: The k-th valid data symbol after the opening symbol (k = 1..N_CH) goes to channel k, which is output bits `ch_data_o[(k-1)*DATA_W +: DATA_W]`.
- R3: After the N_CH-th data symbol of a clean frame is sampled on a clock edge, all channel outputs take the new values and `frame_stb_o` is high for exactly that one following cycle. At all other times the outputs hold their value.
- R4: A symbol with `sym_err_i`=1 in any data slot makes the frame be discarded at its end. The outputs stay unchanged, no strobe is given, and `drop_cnt_o` rises by one.
- R5: An opening symbol that arrives before N_CH data symbols have been received aborts the current frame, adds one to `drop_cnt_o`, and starts a new frame at channel 1.
- R6: A control symbol is never written into a channel output. A K symbol with an error inside a frame takes up a slot and spoils the frame.
- R7: An opening K symbol whose byte differs from HDR_CODE (default 0xBC) sets `cmd_valid_o` for one cycle, with its byte on `cmd_code_o`, in the cycle after it is sampled. The data that follows is parsed as a normal frame. The plain header value gives no command pulse.
- R8: `drop_cnt_o` saturates at 2^DROP_W-1 and never wraps.
- R9: `in_sync_o` is 0 after reset, becomes 1 with the first committed frame, and stays 1 until reset.
- R10: Once a frame is complete, data symbols are ignored until the next opening symbol.
- R11: Cycles with `sym_valid_i`=0 have no effect on frame position or contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sym_valid_i | input | 1 | A decoded symbol is present |
| sym_data_i | input | DATA_W | Decoded byte |
| sym_k_i | input | 1 | Symbol is a control symbol |
| sym_err_i | input | 1 | Decoder flagged a code or disparity error |
| ch_data_o | output | N_CH*DATA_W | Committed samples, channel 1 in the low bits |
| frame_stb_o | output | 1 | One-cycle pulse when the channel outputs update |
| cmd_valid_o | output | 1 | One-cycle pulse for a command opening symbol |
| cmd_code_o | output | DATA_W | Byte of the last command symbol |
| drop_cnt_o | output | DROP_W | Saturating count of discarded frames |
| in_sync_o | output | 1 | Sticky flag: at least one frame committed |

## Verification
The bench moves a corrupted symbol through every slot of a frame and cuts frames short at every length from zero to N_CH-1. A design that commits early, or that fails to poison a frame, would show a partial update or a missing drop count. It also feeds junk before the first header, junk after a finished frame, and K symbols that carry errors. A design that trusts position without a header would then route stray bytes into the outputs. Command headers with several codes, and idle gaps inside frames, expose a design that loses the payload after a command or that advances position on idle cycles. The drop counter is driven past its ceiling to catch a counter that wraps back to zero.

// File: rtl/fp_pkg.sv
package fp_pkg;
  typedef enum logic {
    ST_HUNT  = 1'b0,
    ST_FRAME = 1'b1
  } parse_state_t;

  typedef struct packed {
    logic hdr;  // clean control symbol: opens a frame
    logic cmd;  // opening symbol carrying a command
    logic dat;  // clean data byte
    logic bad;  // anything flagged by the decoder
  } sym_class_t;
endpackage

// File: rtl/fp_sym_classify.sv
module fp_sym_classify
  import fp_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] HDR_CODE = 8'hBC
) (
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              k_i,
  input  logic              err_i,
  output sym_class_t        cls_o
);
  always_comb begin
    cls_o.hdr = valid_i & k_i & ~err_i;
    cls_o.cmd = valid_i & k_i & ~err_i & (data_i != HDR_CODE);
    cls_o.dat = valid_i & ~k_i & ~err_i;
    cls_o.bad = valid_i & err_i;
  end
endmodule

// File: rtl/fp_position_ctr.sv
module fp_position_ctr
  import fp_pkg::*;
#(
  parameter int unsigned N_CH = 4,
  localparam int unsigned POS_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hdr_i,
  input  logic             dat_i,
  input  logic             bad_i,
  output logic [POS_W-1:0] pos_o,
  output logic             wr_en_o,
  output logic             commit_o,
  output logic             drop_o
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(N_CH - 1);

  parse_state_t     state_q;
  logic [POS_W-1:0] pos_q;
  logic             poison_q;
  logic             in_frame, slot, last, spoiled;

  always_comb begin
    in_frame = (state_q == ST_FRAME);
    slot     = in_frame & (dat_i | bad_i);
    last     = (pos_q == LAST_POS);
    spoiled  = poison_q | bad_i;
    wr_en_o  = slot & dat_i;
    commit_o = slot & last & ~spoiled;
    // header mid-frame truncates; spoiled frame is dropped at its last slot
    drop_o   = (hdr_i & in_frame) | (slot & last & spoiled);
    pos_o    = pos_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_HUNT;
      pos_q    <= '0;
      poison_q <= 1'b0;
    end else if (hdr_i) begin
      state_q  <= ST_FRAME;
      pos_q    <= '0;
      poison_q <= 1'b0;
    end else if (slot) begin
      poison_q <= spoiled;
      if (last) begin
        state_q <= ST_HUNT;
        pos_q   <= '0;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fp_lane_store.sv
module fp_lane_store #(
  parameter int unsigned N_CH   = 4,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned POS_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [POS_W-1:0]         pos_i,
  input  logic [DATA_W-1:0]        data_i,
  input  logic                     commit_i,
  output logic [N_CH*DATA_W-1:0]   lanes_o
);
  for (genvar g = 0; g < N_CH; g++) begin : g_lane
    logic [DATA_W-1:0] shadow_q, out_q, next_val;
    logic              hit;

    always_comb begin
      hit      = wr_en_i & (pos_i == POS_W'(g));
      // last lane is taken straight from the bus on the commit cycle
      next_val = hit ? data_i : shadow_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_q <= '0;
        out_q    <= '0;
      end else begin
        if (hit)      shadow_q <= data_i;
        if (commit_i) out_q    <= next_val;
      end
    end

    assign lanes_o[g*DATA_W +: DATA_W] = out_q;
  end
endmodule

// File: rtl/fp_status.sv
module fp_status #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DROP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic              drop_i,
  input  logic              cmd_i,
  input  logic [DATA_W-1:0] code_i,
  output logic              stb_o,
  output logic              cmd_valid_o,
  output logic [DATA_W-1:0] cmd_code_o,
  output logic [DROP_W-1:0] drop_cnt_o,
  output logic              in_sync_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_o       <= 1'b0;
      cmd_valid_o <= 1'b0;
      cmd_code_o  <= '0;
      drop_cnt_o  <= '0;
      in_sync_o   <= 1'b0;
    end else begin
      stb_o       <= commit_i;
      cmd_valid_o <= cmd_i;
      if (cmd_i)    cmd_code_o <= code_i;
      if (commit_i) in_sync_o  <= 1'b1;
      if (drop_i && (drop_cnt_o != '1)) drop_cnt_o <= drop_cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/fp_frame_demux.sv
module fp_frame_demux
  import fp_pkg::*;
#(
  parameter int unsigned N_CH   = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DROP_W = 8,
  parameter logic [DATA_W-1:0] HDR_CODE = 8'hBC
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sym_valid_i,
  input  logic [DATA_W-1:0]      sym_data_i,
  input  logic                   sym_k_i,
  input  logic                   sym_err_i,
  output logic [N_CH*DATA_W-1:0] ch_data_o,
  output logic                   frame_stb_o,
  output logic                   cmd_valid_o,
  output logic [DATA_W-1:0]      cmd_code_o,
  output logic [DROP_W-1:0]      drop_cnt_o,
  output logic                   in_sync_o
);
  localparam int unsigned POS_W = (N_CH > 1) ? $clog2(N_CH) : 1;

  sym_class_t       cls;
  logic [POS_W-1:0] pos;
  logic             wr_en, commit, drop;

  fp_sym_classify #(.DATA_W(DATA_W), .HDR_CODE(HDR_CODE)) u_classify (
    .valid_i (sym_valid_i),
    .data_i  (sym_data_i),
    .k_i     (sym_k_i),
    .err_i   (sym_err_i),
    .cls_o   (cls)
  );

  fp_position_ctr #(.N_CH(N_CH)) u_position (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hdr_i    (cls.hdr),
    .dat_i    (cls.dat),
    .bad_i    (cls.bad),
    .pos_o    (pos),
    .wr_en_o  (wr_en),
    .commit_o (commit),
    .drop_o   (drop)
  );

  fp_lane_store #(.N_CH(N_CH), .DATA_W(DATA_W)) u_lanes (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .pos_i    (pos),
    .data_i   (sym_data_i),
    .commit_i (commit),
    .lanes_o  (ch_data_o)
  );

  fp_status #(.DATA_W(DATA_W), .DROP_W(DROP_W)) u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .commit_i    (commit),
    .drop_i      (drop),
    .cmd_i       (cls.cmd),
    .code_i      (sym_data_i),
    .stb_o       (frame_stb_o),
    .cmd_valid_o (cmd_valid_o),
    .cmd_code_o  (cmd_code_o),
    .drop_cnt_o  (drop_cnt_o),
    .in_sync_o   (in_sync_o)
  );
endmodule

// File: rtl/fp_frame_demux_chk.sv
module fp_frame_demux_chk #(
  parameter int unsigned N_CH   = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DROP_W = 8,
  parameter logic [DATA_W-1:0] HDR_CODE = 8'hBC
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [N_CH*DATA_W-1:0] ch_data_o,
  input logic                   frame_stb_o,
  input logic                   cmd_valid_o,
  input logic [DATA_W-1:0]      cmd_code_o,
  input logic [DROP_W-1:0]      drop_cnt_o,
  input logic                   in_sync_o
);
  assert_stb_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_stb_o |=> !frame_stb_o);

  assert_hold_outputs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_stb_o |-> $stable(ch_data_o));

  assert_drop_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_cnt_o == $past(drop_cnt_o)) || (drop_cnt_o == $past(drop_cnt_o) + 1'b1));

  assert_drop_no_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_cnt_o >= $past(drop_cnt_o));

  assert_cmd_code_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (cmd_code_o != HDR_CODE));

  assert_sync_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(in_sync_o));

  assert_stb_implies_sync_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_stb_o |-> in_sync_o);
endmodule

bind fp_frame_demux fp_frame_demux_chk #(
  .N_CH(N_CH), .DATA_W(DATA_W), .DROP_W(DROP_W), .HDR_CODE(HDR_CODE)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ch_data_o   (ch_data_o),
  .frame_stb_o (frame_stb_o),
  .cmd_valid_o (cmd_valid_o),
  .cmd_code_o  (cmd_code_o),
  .drop_cnt_o  (drop_cnt_o),
  .in_sync_o   (in_sync_o)
);

// File: tb/fp_frame_demux_test.sv
module fp_frame_demux_test;
  localparam int N = 4;
  localparam int W = 8;
  localparam int DW = 3;
  localparam int DROP_MAX = (1 << DW) - 1;
  localparam logic [7:0] HDR = 8'hBC;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         sym_valid_i = 1'b0;
  logic [7:0]   sym_data_i = '0;
  logic         sym_k_i = 1'b0;
  logic         sym_err_i = 1'b0;
  logic [N*W-1:0] ch_data_o;
  logic         frame_stb_o, cmd_valid_o, in_sync_o;
  logic [7:0]   cmd_code_o;
  logic [DW-1:0] drop_cnt_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] exp_ch [N];
  int exp_drop = 0;

  always #2ns clk_i = ~clk_i;

  fp_frame_demux #(.N_CH(N), .DATA_W(W), .DROP_W(DW), .HDR_CODE(HDR)) uut (
    .clk_i, .rst_ni, .sym_valid_i, .sym_data_i, .sym_k_i, .sym_err_i,
    .ch_data_o, .frame_stb_o, .cmd_valid_o, .cmd_code_o, .drop_cnt_o, .in_sync_o
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_lanes(input string req);
    for (int i = 0; i < N; i++) check(req, $sformatf("lane%0d", i), ch_data_o[i*W +: W], exp_ch[i]);
  endtask

  task automatic put(input logic [7:0] d, input logic k, input logic e);
    @(negedge clk_i);
    sym_valid_i = 1'b1; sym_data_i = d; sym_k_i = k; sym_err_i = e;
  endtask

  task automatic gap();
    @(negedge clk_i);
    sym_valid_i = 1'b0; sym_data_i = 8'h00; sym_k_i = 1'b0; sym_err_i = 1'b0;
  endtask

  function automatic logic [7:0] val(input int f, input int i);
    return 8'((f * 37 + i * 11 + 5) & 255);
  endfunction

  task automatic bump_drop();
    if (exp_drop < DROP_MAX) exp_drop++;
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < N; i++) exp_ch[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", "reset lanes", ch_data_o, 0);
    check("R3", "reset stb", frame_stb_o, 0);
    check("R8", "reset drop", drop_cnt_o, 0);
    check("R9", "reset sync", in_sync_o, 0);
    check("R7", "reset cmd", cmd_valid_o, 0);

    // R1: junk before any header, and an errored K symbol
    for (int i = 0; i < N; i++) put(8'h40 + 8'(i), 1'b0, 1'b0);
    put(HDR, 1'b1, 1'b1);
    for (int i = 0; i < N; i++) put(8'h60 + 8'(i), 1'b0, 1'b0);
    gap();
    check("R1", "stb after junk", frame_stb_o, 0);
    check_lanes("R1");
    check("R9", "sync after junk", in_sync_o, 0);
    check("R4", "drop after junk", drop_cnt_o, 0);

    // R2/R3/R11: sweep of clean frames, odd frames with idle gaps
    for (int f = 0; f < 8; f++) begin
      put(HDR, 1'b1, 1'b0);
      for (int i = 0; i < N; i++) begin
        if (f % 2 == 1) gap();
        put(val(f, i), 1'b0, 1'b0);
        exp_ch[i] = val(f, i);
      end
      gap();
      check("R3", "stb on commit", frame_stb_o, 1);
      check_lanes("R2");
      check("R9", "sync set", in_sync_o, 1);
      check("R7", "no cmd for plain header", cmd_valid_o, 0);
      gap();
      check("R3", "stb one cycle", frame_stb_o, 0);
      if (f % 2 == 1) check_lanes("R11");
    end

    // R4: error in each data slot
    for (int p = 0; p < N; p++) begin
      put(HDR, 1'b1, 1'b0);
      for (int i = 0; i < N; i++) put(val(20 + p, i), 1'b0, (i == p));
      bump_drop();
      gap();
      check("R4", "stb on errored frame", frame_stb_o, 0);
      check_lanes("R4");
      check("R4", "drop count", drop_cnt_o, exp_drop);
    end

    // R6: errored K symbol occupying a slot
    for (int p = 0; p < 2; p++) begin
      put(HDR, 1'b1, 1'b0);
      for (int i = 0; i < N; i++) begin
        if (i == p) put(HDR, 1'b1, 1'b1);
        else put(val(30 + p, i), 1'b0, 1'b0);
      end
      bump_drop();
      gap();
      check("R6", "stb with bad K", frame_stb_o, 0);
      check_lanes("R6");
      check("R6", "drop count", drop_cnt_o, exp_drop);
    end

    // R5: truncated frames of every length, then a full frame
    for (int t = 0; t < N; t++) begin
      put(HDR, 1'b1, 1'b0);
      for (int i = 0; i < t; i++) put(val(40 + t, i), 1'b0, 1'b0);
      put(HDR, 1'b1, 1'b0);
      bump_drop();
      for (int i = 0; i < N; i++) begin
        put(val(50 + t, i), 1'b0, 1'b0);
        exp_ch[i] = val(50 + t, i);
      end
      gap();
      check("R5", "stb after restart", frame_stb_o, 1);
      check_lanes("R5");
      check("R6", "no control byte in lanes", (ch_data_o[7:0] == HDR), 0);
      check("R8", "drop count saturating", drop_cnt_o, exp_drop);
    end

    // R8: push further past the ceiling
    for (int j = 0; j < 3; j++) begin
      put(HDR, 1'b1, 1'b0);
      put(8'h11, 1'b0, 1'b0);
      bump_drop();
    end
    put(HDR, 1'b1, 1'b0);
    bump_drop();
    gap();
    check("R8", "drop at ceiling", drop_cnt_o, DROP_MAX);
    check("R8", "model ceiling", exp_drop, DROP_MAX);
    for (int i = 0; i < N; i++) put(val(60, i), 1'b0, 1'b0);
    for (int i = 0; i < N; i++) exp_ch[i] = val(60, i);
    gap();
    check("R11", "stb after idle inside frame", frame_stb_o, 1);
    check_lanes("R11");

    // R7: command headers
    for (int c = 0; c < 4; c++) begin
      logic [7:0] code;
      code = 8'h1C + 8'(c * 32);
      put(code, 1'b1, 1'b0);
      gap();
      check("R7", "cmd pulse", cmd_valid_o, 1);
      check("R7", "cmd code", cmd_code_o, code);
      gap();
      check("R7", "cmd single cycle", cmd_valid_o, 0);
      for (int i = 0; i < N; i++) begin
        put(val(70 + c, i), 1'b0, 1'b0);
        exp_ch[i] = val(70 + c, i);
      end
      gap();
      check("R7", "frame after cmd", frame_stb_o, 1);
      check_lanes("R7");
    end

    // R10: data after a completed frame without a header
    for (int i = 0; i < N; i++) put(8'hA0 + 8'(i), 1'b0, 1'b0);
    gap();
    check("R10", "stb without header", frame_stb_o, 0);
    check_lanes("R10");
    check("R9", "sync sticky", in_sync_o, 1);

    done = 1'b1;
    finish_run();
  end
endmodule